// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is the shifting core of a byte-wide SPI master. It runs one counted burst at a time. The caller gives it a total byte count and a count of sourced bytes, then pulses a start input. The engine pulls the sourced bytes one by one from an external transmit FIFO. Once those run out, it sends 0x00 for the rest of the burst. Every received byte goes into an external receive FIFO unless discard is selected. When the burst ends, the busy indication drops and a sticky completion flag rises.

Bit timing comes from an external divider. That divider supplies a one-cycle `tick` strobe at twice the serial bit rate, and every tick taken during a byte toggles SCLK. Clock polarity, clock phase, bit order and receive discard are captured when a burst is accepted. A FIFO that cannot supply or accept a byte makes the engine pause between bytes, with SCLK parked at its idle level. Chip-select lines are driven either automatically, active while busy, or directly from a level input.

Top module: `spi_burst_engine`

## Requirements
- R1: A `start` pulse with a nonzero `burst_len` raises `busy` on the next clock edge, with `done` low. `busy` stays high until the last byte is finished; then `busy` falls and `done` rises on the same edge. `done` stays set until the next accepted start.
- R2: A burst of N bytes produces exactly 16·N SCLK transitions (8·N clock periods). Outside a byte in flight, SCLK sits at the idle level, which equals `mode_cpol`.
- R3: The first min(`tx_len`, `burst_len`) bytes are each popped once from the transmit FIFO and sent in pop order. Each of the remaining bytes of the burst is sent as 0x00 and pops nothing.
- R4: With `mode_cpha`=0, MOSI is valid before the first SCLK edge of a byte and both sides sample on leading edges. With `mode_cpha`=1, MOSI changes on leading edges and sampling happens on trailing edges. A leading edge is one that leaves the idle level.
- R5: With `lsb_first`=0, bit 7 of each byte goes first on MOSI and the first MISO bit lands in bit 7. With `lsb_first`=1, bit 0 goes first in both directions.
- R6: With `rx_discard`=0, every received byte is pushed once to the receive FIFO, in order. With `rx_discard`=1, `rx_push` never asserts during the burst.
- R7: If a sourced byte is due and `tx_empty` is high, the engine waits with no SCLK edges and SCLK at idle. It never pops from an empty FIFO, and it resumes when data arrives.
- R8: While `rx_full` is high, `rx_push` stays low and the engine waits before the next byte.
- R9: `done` rises only after the last byte of the burst has been pushed. In discard mode, it rises only after the last byte has been sampled.
- R10: A `start` with `burst_len`=0 sets `done` on the next edge without raising `busy` and without any SCLK edge.
- R11: With `cs_manual`=0, output `cs_o[cs_sel]` is at the active level while a burst runs and inactive otherwise. The active level is 1 when `cs_active_high`=1 and 0 when it is 0. All other lines stay inactive. Chip-select outputs are registered, so they follow their inputs one edge later.
- R12: With `cs_manual`=1, `cs_o[cs_sel]` equals `cs_level` regardless of `busy`, and all other lines stay inactive.
- R13: A `start` pulse while `busy` is high is ignored, and the running burst keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a burst |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Bytes taken from the transmit FIFO |
| mode_cpha | input | 1 | Clock phase select |
| mode_cpol | input | 1 | SCLK idle level |
| lsb_first | input | 1 | 1: shift bit 0 first |
| rx_discard | input | 1 | 1: do not store received bytes |
| cs_sel | input | 2 | Index of the chip-select line in use |
| cs_active_high | input | 1 | 1: chip select asserts high |
| cs_manual | input | 1 | 1: selected line follows cs_level |
| cs_level | input | 1 | Level for the selected line in manual mode |
| tick | input | 1 | Half-bit strobe from the clock divider |
| tx_empty | input | 1 | Transmit FIFO has no data |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Consume the head transmit byte |
| rx_full | input | 1 | Receive FIFO cannot accept a byte |
| rx_push | output | 1 | Write rx_data into the receive FIFO |
| rx_data | output | 8 | Last byte received |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Sticky completion flag |

## Verification
The assertions assume several things about the inputs. `tick` is a single-cycle strobe. The mode and count inputs are settled before `start`. `tx_data` is valid whenever `tx_empty` is low. `miso` changes only away from the sampling edge. The bench meets these by generating `tick` every second cycle. It changes configuration only while idle and waits for SCLK to reach its new idle level before starting. It drives MISO from a slave model that moves to the next bit on the falling clock phase after each sampling edge. Random bursts draw their lengths, sourced counts, modes and chip-select index from a seeded generator. Directed cases cover the zero-length burst, FIFO starvation, a full receive FIFO and a start pulse during a burst.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int BYTE_W  = 8;
  localparam int PHASE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_STORE
  } seq_state_e;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic lsb;
    logic discard;
  } xfer_mode_t;

  // Physical bit position of the n-th bit on the wire.
  function automatic logic [2:0] bit_pos(input logic [2:0] n, input logic lsb);
    return lsb ? n : (3'd7 - n);
  endfunction

  // Half-period index 0..15: even = leading edge, odd = trailing edge.
  function automatic logic is_sample_edge(input logic [PHASE_W-1:0] ph, input logic cpha);
    return ph[0] == cpha;
  endfunction

  // Bit index presented on MOSI after a shifting edge at half-period ph.
  function automatic logic [2:0] shift_index(input logic [PHASE_W-1:0] ph, input logic cpha);
    return cpha ? ph[3:1] : (ph[3:1] + 3'd1);
  endfunction

endpackage

// File: rtl/spi_burst_shift.sv
module spi_burst_shift
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              cpha,
  input  logic              lsb,
  input  logic              park_level,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done
);

  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(2 * BYTE_W - 1);

  logic                running;
  logic [PHASE_W-1:0]  phase;
  logic [BYTE_W-1:0]   tx_q;
  logic [BYTE_W-1:0]   rx_q;
  logic                out_bit;
  logic                sclk_q;
  logic                done_q;
  logic                edge_ev;
  logic                last_edge;

  assign edge_ev   = running && tick;
  assign last_edge = edge_ev && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      out_bit <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_edge;
      if (load) begin
        running <= 1'b1;
        phase   <= '0;
        tx_q    <= load_byte;
        rx_q    <= '0;
        out_bit <= load_byte[bit_pos(3'd0, lsb)];
      end else if (edge_ev) begin
        sclk_q <= ~sclk_q;
        phase  <= phase + 1'b1;
        if (is_sample_edge(phase, cpha))
          rx_q[bit_pos(phase[3:1], lsb)] <= miso;
        else if (phase != LAST_PH)
          out_bit <= tx_q[bit_pos(shift_index(phase, cpha), lsb)];
        if (last_edge)
          running <= 1'b0;
      end else if (!running) begin
        sclk_q <= park_level;
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = out_bit;
  assign rx_byte   = rx_q;
  assign byte_done = done_q;

  AST_SCLK_BACK_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (sclk_q == park_level)); // R2

  AST_NO_LOAD_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !running); // R2

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  xfer_mode_t        mode_in,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rx_full,
  input  logic              byte_done,
  output logic              tx_pop,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              rx_push,
  output logic              busy,
  output logic              done,
  output xfer_mode_t        mode_q
);

  seq_state_e       state;
  logic [CNT_W-1:0] burst_rem;
  logic [CNT_W-1:0] tx_rem;
  logic             done_q;
  logic             sourced;
  logic             fetch_ok;
  logic             store_ok;
  logic             last_byte;
  logic             accept;

  assign sourced   = (tx_rem != '0);
  assign fetch_ok  = (state == ST_FETCH) && (!sourced || !tx_empty);
  assign store_ok  = (state == ST_STORE) && (mode_q.discard || !rx_full);
  assign last_byte = (burst_rem == CNT_W'(1));
  assign accept    = (state == ST_IDLE) && start;

  assign tx_pop    = fetch_ok && sourced;
  assign load      = fetch_ok;
  assign load_byte = sourced ? tx_data : '0;
  assign rx_push   = store_ok && !mode_q.discard;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      burst_rem <= '0;
      tx_rem    <= '0;
      done_q    <= 1'b0;
      mode_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (burst_len == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q    <= 1'b0;
            mode_q    <= mode_in;
            burst_rem <= burst_len;
            tx_rem    <= tx_len;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: if (fetch_ok) begin
          if (sourced) tx_rem <= tx_rem - 1'b1;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (byte_done) state <= ST_STORE;
        ST_STORE: if (store_ok) begin
          burst_rem <= burst_rem - 1'b1;
          if (last_byte) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state  <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R7

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy); // R1

  AST_ZERO_LEN_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (burst_len == '0)) |=> (done && !busy)); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !store_ok) |=> (burst_rem == $past(burst_rem))); // R13

  AST_BYTE_END_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (state == ST_SHIFT)); // R2

endmodule

// File: rtl/spi_burst_cs.sv
module spi_burst_cs #(
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic              cs_active_high,
  input  logic              cs_manual,
  input  logic              cs_level,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs_o
);

  logic [NUM_CS-1:0] cs_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic hit;
    logic nxt;
    assign hit = (cs_sel == CS_W'(i));
    always_comb begin
      if (!hit)          nxt = ~cs_active_high;
      else if (cs_manual) nxt = cs_level;
      else if (busy)     nxt = cs_active_high;
      else               nxt = ~cs_active_high;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q[i] <= 1'b1;
      else        cs_q[i] <= nxt;
    end
  end

  assign cs_o = cs_q;

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_q ^ {NUM_CS{~$past(cs_active_high)}}) <= 1); // R11

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int  CNT_W  = 24,
  parameter int  NUM_CS = 4,
  localparam int CS_W   = $clog2(NUM_CS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              mode_cpha,
  input  logic              mode_cpol,
  input  logic              lsb_first,
  input  logic              rx_discard,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic              cs_active_high,
  input  logic              cs_manual,
  input  logic              cs_level,
  input  logic              tick,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_o,
  output logic              busy,
  output logic              done
);

  xfer_mode_t        mode_in;
  xfer_mode_t        mode_q;
  logic              load;
  logic [BYTE_W-1:0] load_byte;
  logic              byte_done;
  logic              park_level;

  assign mode_in    = '{cpha: mode_cpha, cpol: mode_cpol, lsb: lsb_first, discard: rx_discard};
  assign park_level = busy ? mode_q.cpol : mode_cpol;

  spi_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .burst_len (burst_len),
    .tx_len    (tx_len),
    .mode_in   (mode_in),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .rx_full   (rx_full),
    .byte_done (byte_done),
    .tx_pop    (tx_pop),
    .load      (load),
    .load_byte (load_byte),
    .rx_push   (rx_push),
    .busy      (busy),
    .done      (done),
    .mode_q    (mode_q)
  );

  spi_burst_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (load),
    .load_byte  (load_byte),
    .cpha       (mode_q.cpha),
    .lsb        (mode_q.lsb),
    .park_level (park_level),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .rx_byte    (rx_data),
    .byte_done  (byte_done)
  );

  spi_burst_cs #(.NUM_CS(NUM_CS)) u_cs (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_sel         (cs_sel),
    .cs_active_high (cs_active_high),
    .cs_manual      (cs_manual),
    .cs_level       (cs_level),
    .busy           (busy),
    .cs_o           (cs_o)
  );

  AST_NO_EDGE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sclk) || (sclk == mode_cpol)); // R2

endmodule

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [23:0] burst_len = '0;
  logic [23:0] tx_len = '0;
  logic        mode_cpha = 1'b0, mode_cpol = 1'b0, lsb_first = 1'b0, rx_discard = 1'b0;
  logic [1:0]  cs_sel = '0;
  logic        cs_active_high = 1'b0, cs_manual = 1'b0, cs_level = 1'b0;
  logic        tick = 1'b0;
  logic        tx_empty;
  logic [7:0]  tx_data;
  logic        tx_pop;
  logic        rx_full = 1'b0;
  logic        rx_push;
  logic [7:0]  rx_data;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_o;
  logic        busy, done;

  spi_burst_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len), .tx_len(tx_len),
    .mode_cpha(mode_cpha), .mode_cpol(mode_cpol), .lsb_first(lsb_first),
    .rx_discard(rx_discard), .cs_sel(cs_sel), .cs_active_high(cs_active_high),
    .cs_manual(cs_manual), .cs_level(cs_level), .tick(tick), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bpos(input int n, input bit lsb);
    return lsb ? n : 7 - n;
  endfunction

  function automatic logic [7:0] slave_byte(input int k);
    return 8'((k * 53) + 8'h3C);
  endfunction

  // Half-bit strobe every second cycle
  int tcnt = 0;
  always @(posedge clk) begin
    tcnt <= (tcnt == 1) ? 0 : tcnt + 1;
    tick <= (tcnt == 1);
  end

  // Transmit FIFO model
  logic [7:0] txm [64];
  int tx_rd = 0;
  int tx_avail = 0;
  assign tx_empty = (tx_rd >= tx_avail);
  assign tx_data  = txm[tx_rd % 64];
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

  // Receive FIFO model
  logic [7:0] rxm [64];
  int rx_wr = 0;
  always @(posedge clk) if (rx_push) begin
    rxm[rx_wr % 64] <= rx_data;
    rx_wr <= rx_wr + 1;
  end

  // Slave model and edge monitor
  bit cur_cpha = 0, cur_cpol = 0, cur_lsb = 0;
  int edges = 0, samp = 0, samp_base = 0;
  logic sprev = 1'b0;
  logic [7:0] cap [64];

  function automatic logic slave_bit(input int k, input bit lsb);
    logic [7:0] b;
    b = slave_byte(k / 8);
    return b[bpos(k % 8, lsb)];
  endfunction

  assign miso = slave_bit(samp - samp_base, cur_lsb);

  always @(negedge clk) if (rst_n) begin
    if (sclk !== sprev) begin
      edges++;
      if ((sprev == cur_cpol) == (cur_cpha == 1'b0)) begin
        cap[((samp - samp_base) / 8) % 64][bpos((samp - samp_base) % 8, cur_lsb)] = mosi;
        samp++;
      end
    end
    sprev = sclk;
  end

  task automatic run_burst(input int len, input int txl, input bit cpha, input bit cpol,
                           input bit lsb, input bit disc, input int csi, input bit cah,
                           input bit stall, input bit rxstall, input bit restart);
    int base, rxb, e0, e1, exp_pops, wd;
    logic [7:0] expb;
    @(negedge clk);
    mode_cpha = cpha; mode_cpol = cpol; lsb_first = lsb; rx_discard = disc;
    cs_sel = 2'(csi); cs_active_high = cah; cs_manual = 1'b0;
    cur_cpha = cpha; cur_cpol = cpol; cur_lsb = lsb;
    base = tx_rd;
    for (int i = 0; i < txl; i++) txm[(base + i) % 64] = 8'($urandom);
    tx_avail = base + ((stall && txl > 1) ? txl / 2 : txl);
    rxb = rx_wr;
    rx_full = rxstall;
    repeat (3) @(negedge clk);
    chk(sclk == cpol, "R2 idle level", int'(sclk), int'(cpol));
    samp_base = samp;
    e0 = edges;
    burst_len = 24'(len); tx_len = 24'(txl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      chk(done && !busy, "R10 zero-length finish", int'({busy, done}), 1);
      repeat (20) @(negedge clk);
      chk(edges == e0, "R10 no SCLK edges", edges - e0, 0);
      return;
    end
    chk(busy && !done, "R1 busy after start", int'({busy, done}), 2);
    @(negedge clk);
    for (int j = 0; j < 4; j++)
      chk(cs_o[j] == ((j == csi) ? cah : !cah), "R11 auto chip select", int'(cs_o[j]),
          int'((j == csi) ? cah : !cah));
    if (restart) begin
      burst_len = 24'(len + 5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (stall && txl > 1) begin
      wd = 0;
      while (tx_rd < tx_avail && wd < 5000) begin @(negedge clk); wd++; end
      repeat (60) @(negedge clk);
      e1 = edges;
      repeat (100) @(negedge clk);
      chk(edges == e1, "R7 no edges while starved", edges - e1, 0);
      chk(sclk == cpol && busy, "R7 parked while starved", int'(sclk), int'(cpol));
      tx_avail = base + txl;
    end
    if (rxstall) begin
      repeat (150) @(negedge clk);
      chk(rx_wr == rxb, "R8 no push while full", rx_wr - rxb, 0);
      chk(busy && !done, "R9 not done while stalled", int'({busy, done}), 2);
      rx_full = 1'b0;
    end
    wd = 0;
    while (busy && wd < 20000) begin @(negedge clk); wd++; end
    chk(!busy && done, "R1 finish flags", int'({busy, done}), 1);
    chk(rx_wr - rxb == (disc ? 0 : len), "R9 pushes complete at done", rx_wr - rxb, disc ? 0 : len);
    chk(edges - e0 == 16 * len, "R2 SCLK edge count", edges - e0, 16 * len);
    if (restart) chk(edges - e0 == 16 * len, "R13 start ignored while busy", edges - e0, 16 * len);
    chk(samp - samp_base == 8 * len, "R4 sampled bits", samp - samp_base, 8 * len);
    exp_pops = (txl < len) ? txl : len;
    chk(tx_rd - base == exp_pops, "R3 pop count", tx_rd - base, exp_pops);
    for (int i = 0; i < len; i++) begin
      expb = (i < txl) ? txm[(base + i) % 64] : 8'h00;
      chk(cap[i % 64] == expb, lsb ? "R5 mosi byte lsb-first" : "R3 R4 mosi byte",
          int'(cap[i % 64]), int'(expb));
      if (!disc)
        chk(rxm[(rxb + i) % 64] == slave_byte(i), "R6 received byte",
            int'(rxm[(rxb + i) % 64]), int'(slave_byte(i)));
    end
    if (disc) chk(rx_wr == rxb, "R6 discard stores nothing", rx_wr - rxb, 0);
  endtask

  task automatic manual_cs(input int csi, input bit cah, input bit lvl);
    logic [3:0] expv;
    @(negedge clk);
    cs_manual = 1'b1; cs_sel = 2'(csi); cs_active_high = cah; cs_level = lvl;
    repeat (2) @(negedge clk);
    expv = {4{!cah}};
    expv[csi] = lvl;
    chk(cs_o == expv, "R12 manual chip select", int'(cs_o), int'(expv));
    cs_manual = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 reset flags", int'({busy, done}), 0);
    chk(sclk == 1'b0, "R2 reset SCLK idle", int'(sclk), 0);
    chk(cs_o == 4'b1111, "R11 reset chip selects inactive", int'(cs_o), 15);
    chk(!tx_pop && !rx_push, "R3 no FIFO traffic at reset", int'({tx_pop, rx_push}), 0);

    run_burst(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_burst(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    run_burst(4, 4, 1, 0, 0, 0, 2, 1, 0, 0, 0);
    run_burst(4, 4, 0, 1, 0, 0, 3, 0, 0, 0, 0);
    run_burst(4, 4, 1, 1, 0, 0, 0, 1, 0, 0, 0);
    run_burst(6, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    run_burst(3, 7, 1, 0, 0, 0, 2, 0, 0, 0, 0);
    run_burst(5, 5, 0, 1, 1, 0, 0, 1, 0, 0, 0);
    run_burst(5, 5, 1, 0, 0, 1, 3, 0, 0, 0, 0);
    run_burst(8, 6, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    run_burst(6, 6, 1, 1, 1, 0, 2, 0, 0, 1, 0);
    run_burst(4, 4, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    run_burst(0, 3, 1, 1, 0, 0, 2, 1, 0, 0, 0);
    manual_cs(2, 0, 0);
    manual_cs(2, 0, 1);
    manual_cs(1, 1, 1);
    manual_cs(3, 1, 0);

    for (int n = 0; n < 12; n++) begin
      int len, txl;
      len = 1 + int'($urandom % 24);
      txl = int'($urandom % (len + 4));
      run_burst(len, txl, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 4), 1'($urandom), 0, 0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule